// File: doc/BRIEF.md
# Serial Flash Command Responder

This block is the device side of a small serial flash, built so that a host-side controller can be exercised against real, synthesizable logic. The host frames each command with an active-low select and clocks bits in on `sd_in` at the rising edge of `sck`. Responses go out on `sd_out` and change on the falling edge. The block runs on its own system clock. It oversamples the three serial inputs, so `sck` must be several times slower than `clk`.

Five commands are understood: set write enable, read status, read data, page write and whole-device erase. The status byte holds two flags, a busy flag for a self-timed cycle in progress and a write-enable flag. Page data is collected in a staging buffer and is committed only when the host closes the frame on a byte boundary. Commit runs as a counter-timed cycle that merges each new byte into memory with a bitwise AND. Erase is also counter-timed and returns every byte to 0xFF. The host always sends a 24-bit address. Only the low `ADDR_BITS` bits of it are used, so one address stream serves any array size.

Top module: `flash_cmd_responder`

## Requirements
- R1: After reset the status byte reads 0x00, every memory byte reads 0xFF, and `sd_out` is 0 while `cs_n` is high.
- R2: Opcode 0x06 sets the write-enable flag, which is bit 1 of the status byte.
- R3: Opcode 0x05 returns the status byte MSB first, in the form {6'b0, write-enable at bit 1, busy at bit 0}. The byte is sent again for every further byte clocked while `cs_n` stays low, and each copy shows the current flags.
- R4: Opcode 0x03 followed by three address bytes (MSB first) returns memory bytes starting at that address, one per byte clocked. The address increments and wraps at the array size. Address bits at and above `ADDR_BITS` are ignored.
- R5: Opcode 0x02 followed by three address bytes and data bytes is a page write. Each memory byte becomes old AND new. The column wraps within the 256-byte page, and when a column is written twice in one command the later byte is the one merged.
- R6: A page write is committed only if `cs_n` rises on a byte boundary after at least one data byte. Otherwise it is discarded, leaving memory and the write-enable flag unchanged.
- R7: Opcode 0xC7, with `cs_n` rising right after its eighth bit, erases every byte to 0xFF. If any further bit is clocked before `cs_n` rises, no erase starts and the write-enable flag stays set.
- R8: A page write or erase sent while the write-enable flag is 0 is ignored.
- R9: A committed page write or erase sets the busy flag at once and clears the write-enable flag. Busy stays 1 for `PROG_CYCLES` or `ERASE_CYCLES` clocks (never fewer than the page or array size) and then returns to 0.
- R10: While busy is 1, only the status read has any effect. Write enable, read, page write and erase are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial bit clock; input sampled on rise, output changed on fall |
| sd_in | input | 1 | Serial command, address and data from the host, MSB first |
| sd_out | output | 1 | Serial response to the host, MSB first; 0 while deselected |

## Verification
The hardest case to reach from the pins is a frame that is well formed up to its last moment and then closes in the wrong place. Examples are an erase opcode with one extra bit, and a page write that stops three bits into a byte or right after its address. Each of these has to leave a visible trace in the status byte and in memory. The bench drives raw bit counts rather than whole bytes, and then reads status and data back over the same pins. A second hard case is a command that arrives during a self-timed cycle. The bench sends it inside the erase window, before it starts polling status, and checks afterwards that the write-enable flag never came up.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

  localparam logic [7:0] OPC_WR_EN      = 8'h06;
  localparam logic [7:0] OPC_STATUS     = 8'h05;
  localparam logic [7:0] OPC_READ       = 8'h03;
  localparam logic [7:0] OPC_PAGE_WR    = 8'h02;
  localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;

  typedef enum logic [2:0] {
    FR_OPC, FR_ADDR, FR_PROG, FR_STAT, FR_READ, FR_ARM, FR_SKIP
  } frame_st_e;

  typedef enum logic [1:0] {ENG_IDLE, ENG_ERASE, ENG_PROG} eng_e;

  // self-timed length never shorter than the number of bytes it must visit
  function automatic int unsigned cycle_len(int unsigned req, int unsigned floor_v);
    return (req > floor_v) ? req : floor_v;
  endfunction

  // programming can only clear bits
  function automatic logic [7:0] and_merge(logic [7:0] old_v, logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  function automatic logic [7:0] status_byte(logic wel, logic wip);
    return {6'b0, wel, wip};
  endfunction

endpackage

// File: rtl/flash_serial_front.sv
module flash_serial_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       sd_i,
  input  logic [7:0] tx_byte_i,
  output logic       sd_o,
  output logic       frame_start_o,
  output logic       frame_end_o,
  output logic       aligned_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  logic [1:0] cs_sy, sck_sy, sd_sy;
  logic       cs_d, sck_d;
  logic       cs_s, sck_s, sd_s, sel;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= 2'b11;
      sck_sy <= 2'b00;
      sd_sy  <= 2'b00;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n_i};
      sck_sy <= {sck_sy[0], sck_i};
      sd_sy  <= {sd_sy[0], sd_i};
      cs_d   <= cs_sy[1];
      sck_d  <= sck_sy[1];
    end
  end

  assign cs_s          = cs_sy[1];
  assign sck_s         = sck_sy[1];
  assign sd_s          = sd_sy[1];
  assign sel           = ~cs_s;
  assign frame_start_o = ~cs_s & cs_d;
  assign frame_end_o   = cs_s & ~cs_d;
  assign sck_rise      = sel & sck_s & ~sck_d;
  assign sck_fall      = sel & ~sck_s & sck_d;
  assign aligned_o     = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh_in      <= '0;
      tx_sh      <= '0;
      sd_o       <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (frame_start_o) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh_in   <= {sh_in[5:0], sd_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_in, sd_s};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          sd_o  <= tx_byte_i[7];
          tx_sh <= tx_byte_i[6:0];
        end else begin
          sd_o  <= tx_sh[6];
          tx_sh <= {tx_sh[5:0], 1'b0};
        end
      end
      if (cs_s) sd_o <= 1'b0;
    end
  end

  // R3: bytes are only assembled inside a frame
  p_byte_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> $past(sel));

  // R1: output idle low while deselected
  p_out_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> !sd_o);

endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int PAGE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [PAGE_BITS-1:0] wcol_i,
  input  logic [7:0]           wdata_i,
  input  logic [PAGE_BITS-1:0] ridx_i,
  output logic [7:0]           rdata_o,
  output logic                 rvalid_o
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;

  logic [7:0]         data_q [PAGE_SZ];
  logic [PAGE_SZ-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we_i) data_q[wcol_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (clr_i) valid_q <= '0;
    else if (we_i)  valid_q[wcol_i] <= 1'b1;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = valid_q[ridx_i];

endmodule

// File: rtl/flash_mem_array.sv
module flash_mem_array #(
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_BITS-1:0] waddr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           old_o,
  input  logic [ADDR_BITS-1:0] raddr_i,
  output logic [7:0]           rdata_o
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign old_o   = mem_q[waddr_i];
  assign rdata_o = mem_q[raddr_i];

  // R5: any write other than an erase value must not raise a cleared bit
  p_only_erase_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wdata_i != 8'hFF) |-> ((wdata_i & ~old_o) == 8'h00));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_resp_pkg::*;
#(
  parameter int ADDR_BITS    = 9,
  parameter int PAGE_BITS    = 8,
  parameter int ERASE_CYCLES = 600,
  parameter int PROG_CYCLES  = 300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start_i,
  input  logic                 frame_end_i,
  input  logic                 aligned_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  output logic [7:0]           tx_byte_o,
  output logic                 buf_clr_o,
  output logic                 buf_we_o,
  output logic [PAGE_BITS-1:0] buf_col_o,
  output logic [7:0]           buf_wdata_o,
  output logic [PAGE_BITS-1:0] buf_idx_o,
  input  logic [7:0]           buf_rdata_i,
  input  logic                 buf_valid_i,
  output logic                 mem_we_o,
  output logic [ADDR_BITS-1:0] mem_waddr_o,
  output logic [7:0]           mem_wdata_o,
  input  logic [7:0]           mem_old_i,
  output logic [ADDR_BITS-1:0] mem_raddr_o,
  input  logic [7:0]           mem_rdata_i
);
  localparam int DEPTH     = 1 << ADDR_BITS;
  localparam int PAGE_SZ   = 1 << PAGE_BITS;
  localparam int PG_W      = ADDR_BITS - PAGE_BITS;
  localparam int ERASE_LEN = cycle_len(ERASE_CYCLES, DEPTH);
  localparam int PROG_LEN  = cycle_len(PROG_CYCLES, PAGE_SZ);
  localparam int MAX_LEN   = (ERASE_LEN > PROG_LEN) ? ERASE_LEN : PROG_LEN;
  localparam int CNT_W     = $clog2(MAX_LEN) + 1;

  frame_st_e              fst;
  eng_e                   eng;
  logic                   is_read, got_data, wel, wip;
  logic [1:0]             addr_cnt;
  logic [ADDR_BITS-1:0]   addr_q, nxt_addr, rd_addr;
  logic [PAGE_BITS-1:0]   col;
  logic [PG_W-1:0]        page_q;
  logic [CNT_W-1:0]       cnt;
  logic                   start_erase, start_prog, cyc_done;

  assign wip       = (eng != ENG_IDLE);
  // shifting bytes into an ADDR_BITS-wide register drops unused high bits
  assign nxt_addr  = ADDR_BITS'({addr_q, byte_i});

  assign start_erase = frame_end_i && fst == FR_ARM && aligned_i;
  assign start_prog  = frame_end_i && fst == FR_PROG && aligned_i && got_data;
  assign cyc_done    = (eng == ENG_ERASE && cnt == CNT_W'(ERASE_LEN - 1)) ||
                       (eng == ENG_PROG  && cnt == CNT_W'(PROG_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst      <= FR_SKIP;
      eng      <= ENG_IDLE;
      is_read  <= 1'b0;
      got_data <= 1'b0;
      wel      <= 1'b0;
      addr_cnt <= '0;
      addr_q   <= '0;
      rd_addr  <= '0;
      col      <= '0;
      page_q   <= '0;
      cnt      <= '0;
    end else begin
      if (frame_start_i) begin
        fst      <= FR_OPC;
        addr_cnt <= '0;
        got_data <= 1'b0;
      end else if (byte_vld_i) begin
        case (fst)
          FR_OPC: begin
            case (byte_i)
              OPC_WR_EN: begin
                if (!wip) wel <= 1'b1;
                fst <= FR_SKIP;
              end
              OPC_STATUS: fst <= FR_STAT;
              OPC_READ: begin
                is_read <= 1'b1;
                fst     <= wip ? FR_SKIP : FR_ADDR;
              end
              OPC_PAGE_WR: begin
                is_read <= 1'b0;
                fst     <= (!wip && wel) ? FR_ADDR : FR_SKIP;
              end
              OPC_CHIP_ERASE: fst <= (!wip && wel) ? FR_ARM : FR_SKIP;
              default: fst <= FR_SKIP;
            endcase
          end
          FR_ADDR: begin
            addr_q   <= nxt_addr;
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'd2) begin
              if (is_read) begin
                rd_addr <= nxt_addr;
                fst     <= FR_READ;
              end else begin
                col    <= nxt_addr[PAGE_BITS-1:0];
                page_q <= nxt_addr[ADDR_BITS-1:PAGE_BITS];
                fst    <= FR_PROG;
              end
            end
          end
          FR_PROG: begin
            col      <= col + 1'b1;
            got_data <= 1'b1;
          end
          FR_READ: rd_addr <= rd_addr + 1'b1;
          FR_ARM:  fst <= FR_SKIP;
          default: ;
        endcase
      end

      if (start_erase || start_prog) begin
        eng <= start_erase ? ENG_ERASE : ENG_PROG;
        cnt <= '0;
        wel <= 1'b0;
        fst <= FR_SKIP;
      end else if (wip) begin
        cnt <= cnt + 1'b1;
        if (cyc_done) eng <= ENG_IDLE;
      end
    end
  end

  // page staging
  assign buf_clr_o   = byte_vld_i && fst == FR_OPC && byte_i == OPC_PAGE_WR && !wip && wel;
  assign buf_we_o    = byte_vld_i && fst == FR_PROG;
  assign buf_col_o   = col;
  assign buf_wdata_o = byte_i;
  assign buf_idx_o   = cnt[PAGE_BITS-1:0];

  // self-timed engine visits one byte per clock
  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = cnt[ADDR_BITS-1:0];
    mem_wdata_o = 8'hFF;
    if (eng == ENG_ERASE) begin
      mem_we_o = (cnt < CNT_W'(DEPTH));
    end else if (eng == ENG_PROG) begin
      mem_waddr_o = {page_q, cnt[PAGE_BITS-1:0]};
      mem_wdata_o = and_merge(mem_old_i, buf_rdata_i);
      mem_we_o    = (cnt < CNT_W'(PAGE_SZ)) && buf_valid_i;
    end
  end

  assign mem_raddr_o = rd_addr;
  assign tx_byte_o   = (fst == FR_READ) ? mem_rdata_i : status_byte(wel, wip);

  // R10: a new cycle is never armed while one runs
  p_start_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_erase || start_prog) |-> !wip);

  // R9: starting a cycle raises busy and drops write enable
  p_start_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_erase || start_prog) |=> (wip && !wel));

  // R9: busy ends only after the full counted length
  p_cycle_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> ($past(cnt) == (($past(eng) == ENG_ERASE) ?
                    CNT_W'(ERASE_LEN - 1) : CNT_W'(PROG_LEN - 1))));

  // R10: staging buffer is untouched during a self-timed cycle
  p_buf_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (!buf_we_o && !buf_clr_o));

  // R8: write enable is never set by a busy-time command
  p_wel_rise_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(!wip));

endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder #(
  parameter int ADDR_BITS    = 9,
  parameter int PAGE_BITS    = 8,
  parameter int ERASE_CYCLES = 600,
  parameter int PROG_CYCLES  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sd_in,
  output logic sd_out
);
  logic                 frame_start, frame_end, aligned, byte_vld;
  logic [7:0]           rx_byte, tx_byte;
  logic                 buf_clr, buf_we, buf_valid;
  logic [PAGE_BITS-1:0] buf_col, buf_idx;
  logic [7:0]           buf_wdata, buf_rdata;
  logic                 mem_we;
  logic [ADDR_BITS-1:0] mem_waddr, mem_raddr;
  logic [7:0]           mem_wdata, mem_old, mem_rdata;

  flash_serial_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sd_i(sd_in),
    .tx_byte_i(tx_byte), .sd_o(sd_out), .frame_start_o(frame_start),
    .frame_end_o(frame_end), .aligned_o(aligned), .byte_vld_o(byte_vld),
    .byte_o(rx_byte)
  );

  flash_cmd_ctrl #(
    .ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .frame_end_i(frame_end), .aligned_i(aligned), .byte_vld_i(byte_vld),
    .byte_i(rx_byte), .tx_byte_o(tx_byte), .buf_clr_o(buf_clr),
    .buf_we_o(buf_we), .buf_col_o(buf_col), .buf_wdata_o(buf_wdata),
    .buf_idx_o(buf_idx), .buf_rdata_i(buf_rdata), .buf_valid_i(buf_valid),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_old_i(mem_old), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata)
  );

  flash_page_buf #(.PAGE_BITS(PAGE_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .we_i(buf_we),
    .wcol_i(buf_col), .wdata_i(buf_wdata), .ridx_i(buf_idx),
    .rdata_o(buf_rdata), .rvalid_o(buf_valid)
  );

  flash_mem_array #(.ADDR_BITS(ADDR_BITS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .old_o(mem_old), .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

endmodule

// File: tb/flash_cmd_responder_tb.sv
module flash_cmd_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // system clocks per serial half period

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sd_in = 1'b0;
  logic sd_out;
  int   n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sd_in(sd_in), .sd_out(sd_out)
  );

  // table entry: {set write enable first, 24-bit address, data byte, expected readback}
  localparam int NVEC = 6;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b1, 24'h000010, 8'hA5, 8'hA5},   // R5 fresh byte
    {1'b1, 24'h000010, 8'h3C, 8'h24},   // R5 AND with previous A5
    {1'b1, 24'h0001FF, 8'h0F, 8'h0F},
    {1'b1, 24'hFE03FF, 8'hF3, 8'h03},   // R4 high address bits ignored
    {1'b0, 24'h000123, 8'h00, 8'hFF},   // R8 no write enable
    {1'b1, 24'h000123, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      sd_in = tx[i];
      wait_clk(HALF);
      sck   = 1'b1;
      rx[i] = sd_out;
      wait_clk(HALF);
      sck   = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  task automatic simple_cmd(input logic [7:0] opc);
    logic [7:0] rx;
    frame_open();
    xfer(opc, rx);
    frame_close();
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] rx;
    xfer(a[23:16], rx);
    xfer(a[15:8], rx);
    xfer(a[7:0], rx);
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [7:0] rx;
    frame_open();
    xfer(8'h05, rx);
    xfer(8'h00, st);
    frame_close();
  endtask

  task automatic read_byte(input logic [23:0] a, output logic [7:0] d);
    logic [7:0] rx;
    frame_open();
    xfer(8'h03, rx);
    send_addr(a);
    xfer(8'h00, d);
    frame_close();
  endtask

  task automatic page_write(input logic [23:0] a, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] rx;
    frame_open();
    xfer(8'h02, rx);
    send_addr(a);
    if (n > 0) xfer(d0, rx);
    if (n > 1) xfer(d1, rx);
    if (n > 2) xfer(d2, rx);
    frame_close();
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] st;
    int polls = 0;
    read_status(st);
    while (st[0] && polls < 40) begin
      polls++;
      read_status(st);
    end
    check(req, st & 8'h01, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] st, d, d2, d3;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 sd_out idle", {7'b0, sd_out}, 8'h00);
    read_status(st);
    check("R1 status after reset", st, 8'h00);
    read_byte(24'h0001AB, d);
    check("R1 memory erased", d, 8'hFF);

    // R2 write enable
    simple_cmd(8'h06);
    read_status(st);
    check("R2 write enable sets bit1", st, 8'h02);

    // table of single-byte page writes with readback
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][40]) simple_cmd(8'h06);
      page_write(VEC[v][39:16], 1, VEC[v][15:8], 8'h00, 8'h00);
      wait_idle("R9 write cycle ends");
      read_byte(VEC[v][39:16], d);
      check($sformatf("R5 table entry %0d", v), d, VEC[v][7:0]);
    end

    // R5 column wrap within page 0x100..0x1FF
    simple_cmd(8'h06);
    page_write(24'h0001FE, 3, 8'h11, 8'h22, 8'h33);
    wait_idle("R9 wrap write ends");
    read_byte(24'h0001FE, d);
    check("R5 wrap col FE", d, 8'h11);
    read_byte(24'h0001FF, d);
    check("R5 wrap col FF AND", d, 8'h02);
    read_byte(24'h000100, d);
    check("R5 wrap to page start", d, 8'h33);

    // R4 sequential read across bytes, incrementing address
    frame_open();
    xfer(8'h03, d);
    send_addr(24'h00000F);
    xfer(8'h00, d);
    xfer(8'h00, d2);
    xfer(8'h00, d3);
    frame_close();
    check("R4 seq byte 0", d, 8'hFF);
    check("R4 seq byte 1", d2, 8'h24);
    check("R4 seq byte 2", d3, 8'hFF);

    // R6 partial byte discards page write
    simple_cmd(8'h06);
    frame_open();
    xfer(8'h02, d);
    send_addr(24'h000050);
    xfer(8'h00, d);
    send_bits(8'h00, 3, d);
    frame_close();
    read_status(st);
    check("R6 partial byte: no cycle, wel kept", st, 8'h02);
    read_byte(24'h000050, d);
    check("R6 partial byte: memory kept", d, 8'hFF);

    // R6 address only, no data byte
    page_write(24'h000060, 0, 8'h00, 8'h00, 8'h00);
    read_status(st);
    check("R6 no data: no cycle", st, 8'h02);
    read_byte(24'h000060, d);
    check("R6 no data: memory kept", d, 8'hFF);

    // R7 erase opcode followed by an extra bit is not armed
    frame_open();
    xfer(8'hC7, d);
    send_bits(8'h00, 1, d);
    frame_close();
    read_status(st);
    check("R7 extra bit: no erase, wel kept", st, 8'h02);
    read_byte(24'h000010, d);
    check("R7 extra bit: memory kept", d, 8'h24);

    // R7/R9/R10 proper erase
    simple_cmd(8'hC7);
    frame_open();
    xfer(8'h05, d);
    xfer(8'h00, d2);
    xfer(8'h00, d3);
    frame_close();
    check("R9 busy set wel cleared", d2, 8'h01);
    check("R3 status repeated", d3, 8'h01);
    simple_cmd(8'h06);               // ignored while busy
    wait_idle("R9 erase ends");
    read_status(st);
    check("R10 write enable ignored while busy", st, 8'h00);
    read_byte(24'h000010, d);
    check("R7 erase sets FF", d, 8'hFF);
    read_byte(24'h000123, d);
    check("R7 erase sets FF other page", d, 8'hFF);

    // R8 erase without write enable
    simple_cmd(8'h06);
    page_write(24'h000020, 1, 8'h5A, 8'h00, 8'h00);
    wait_idle("R9 write ends");
    simple_cmd(8'hC7);
    read_status(st);
    check("R8 erase without wel: idle", st, 8'h00);
    read_byte(24'h000020, d);
    check("R8 erase without wel: memory kept", d, 8'h5A);

    finish_run();
  end

endmodule